// File: doc/BRIEF.md
# SPI GPIO Port Expander

This block is an SPI slave in mode 0 that gives a host access to an 8-bit general-purpose I/O port. Access goes through a small set of byte-wide registers. The host opens a frame by pulling chip select low and then sends three kinds of byte in turn:

- a control byte, which holds a fixed family code, a device address and a read/write flag;
- a register address byte;
- any number of data bytes.

On a write frame the data bytes are stored into the registers. On a read frame the slave returns register contents on MISO.

The block drives the pad output values and the per-pin output enables. It samples the pad inputs through a synchronizer. Its system clock oversamples SCLK, chip select and MOSI, so the SPI signals need no clock domain of their own. Up to eight instances can share one chip select, each with a different value on its address strap pins. A configuration bit turns this address matching on. A second configuration bit decides whether the register pointer advances after each data byte or stays where it is.

Top module: `spi_gpio_expander`

## Requirements
- R1: After reset the direction register (0x00) reads 0xFF and every other register reads 0x00, pad_oe is 0x00, pad_out is 0x00 and miso_oe is low.
- R2: A frame is a control byte, then a register address byte, then data bytes, each sent MSB first. MOSI is sampled on SCLK rising edges and MISO changes after SCLK falling edges. In the control byte, bits 7:4 hold the family code, bits 3:1 the device address and bit 0 the direction, where 1 means read.
- R3: miso_oe is high only during the data bytes of a read frame that this device accepted. It stays low during the control byte and the address byte.
- R4: When configuration bit 5 (register 0x05) is 0, the pointer advances after each data byte. From 0x0A or any higher address it moves to 0x00. One frame can therefore read or write consecutive registers.
- R5: pad_oe bit i is the inverse of direction bit i, and pad_out equals the output latch. A write to 0x09 or to 0x0A updates the latch, and a read of 0x0A returns the latch.
- R6: A read of 0x09 returns the synchronized pad inputs XOR the polarity register (0x01). A polarity bit of 1 inverts that pin.
- R7: Registers 0x02, 0x03, 0x04 and 0x06 are plain read/write storage. Registers 0x07 and 0x08, and every address from 0x0B to 0xFF, read as 0x00 and ignore writes.
- R8: When configuration bit 5 is 1, the pointer stays on the addressed register for the whole frame. Repeated reads return the same register, and repeated writes leave the last byte in it.
- R9: When configuration bit 3 is 1, a frame is accepted only if control bits 3:1 equal strap_addr. When the bit is 0, the address field is ignored. A frame that is not accepted changes no register and leaves miso_oe low.
- R10: A control byte whose upper nibble is not 0100 causes the whole frame to be ignored. No register changes and miso_oe stays low.
- R11: Chip select going high at any point ends the frame. A partially shifted byte is discarded without being written, and the next frame starts again at the control byte.
- R12: The configuration register stores and returns all eight bits, including the two interrupt-output option bits 2 and 1, which have no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI lines |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_addr | input | 3 | Hardware address strap |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_out | output | 8 | Pad output values (output latch) |
| pad_oe | output | 8 | Per-pin output enables |

## Verification
The bench keeps a behavioural model of the register file and the frame rules. It compares the pads against that model on every clock and checks every returned byte against it.

It targets the following corner cases:

- **Pointer wrap past 0x0A.** It reads bursts that cross 0x0A and bursts that start above it. A design that wraps wrongly returns stale or zero bytes in place of register 0x00.
- **Pointer hold.** With auto-increment disabled it reads and writes repeatedly at one address. A design that keeps advancing returns bytes from the neighbouring registers.
- **Address matching and foreign family codes.** It sends frames with a wrong device address while matching is on, and frames with a bad family code. A design that accepts either would change the latch or drive MISO while another device owns the line.
- **Abort in mid-byte.** It raises chip select partway through a data byte. A design that commits the half-shifted byte, or keeps its bit count, corrupts the latch or misreads the next frame.

// File: rtl/spi_gpio_expander.sv
module spi_gpio_expander #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strap_addr,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  output logic       miso_oe,
  input  logic [7:0] pad_in,
  output logic [7:0] pad_out,
  output logic [7:0] pad_oe
);
  localparam logic [3:0] FAMILY   = 4'b0100;
  localparam logic [7:0] LAST_REG = 8'h0A;
  localparam int         SEQ_BIT  = 5;
  localparam int         ADR_BIT  = 3;

  typedef enum logic [1:0] {PH_CTRL, PH_ADDR, PH_DATA} phase_t;

  logic [SYNC_STAGES-1:0] sclk_sh, cs_sh, mosi_sh;
  logic [7:0] pin_sh [SYNC_STAGES];
  logic sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_sh <= '0;
      cs_sh   <= '1;
      mosi_sh <= '0;
      sclk_d  <= 1'b0;
      for (int i = 0; i < SYNC_STAGES; i++) pin_sh[i] <= '0;
    end else begin
      sclk_sh <= {sclk_sh[SYNC_STAGES-2:0], sclk};
      cs_sh   <= {cs_sh[SYNC_STAGES-2:0], cs_n};
      mosi_sh <= {mosi_sh[SYNC_STAGES-2:0], mosi};
      sclk_d  <= sclk_sh[SYNC_STAGES-1];
      pin_sh[0] <= pad_in;
      for (int i = 1; i < SYNC_STAGES; i++) pin_sh[i] <= pin_sh[i-1];
    end
  end

  wire sclk_s = sclk_sh[SYNC_STAGES-1];
  wire cs_s   = cs_sh[SYNC_STAGES-1];
  wire mosi_s = mosi_sh[SYNC_STAGES-1];
  wire rise   = sclk_s & ~sclk_d;
  wire fall   = ~sclk_s & sclk_d;

  logic [2:0] bit_cnt;
  phase_t     phase;
  logic       sel, rd, miso_q;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh, ptr;
  logic [7:0] r_dir, r_pol, r_ien, r_dflt, r_icon, r_cfg, r_pu, r_lat;

  wire [7:0] byte_in   = {rx_sh, mosi_s};
  wire       byte_done = rise && !cs_s && (bit_cnt == 3'd7);
  wire       match     = (byte_in[7:4] == FAMILY) &&
                         (!r_cfg[ADR_BIT] || byte_in[3:1] == strap_addr);
  wire [7:0] ptr_adv   = r_cfg[SEQ_BIT] ? ptr :
                         (ptr >= LAST_REG) ? 8'h00 : ptr + 8'h01;
  wire [7:0] load_addr = (phase == PH_ADDR) ? byte_in : ptr_adv;
  wire [7:0] port_val  = pin_sh[SYNC_STAGES-1] ^ r_pol;
  wire       wr_en     = byte_done && phase == PH_DATA && sel && !rd;

  logic [7:0] rd_load;
  always_comb begin
    case (load_addr)
      8'h00:   rd_load = r_dir;
      8'h01:   rd_load = r_pol;
      8'h02:   rd_load = r_ien;
      8'h03:   rd_load = r_dflt;
      8'h04:   rd_load = r_icon;
      8'h05:   rd_load = r_cfg;
      8'h06:   rd_load = r_pu;
      8'h09:   rd_load = port_val;
      8'h0A:   rd_load = r_lat;
      default: rd_load = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      phase   <= PH_CTRL;
      sel     <= 1'b0;
      rd      <= 1'b0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      ptr     <= '0;
      miso_q  <= 1'b0;
    end else if (cs_s) begin
      bit_cnt <= '0;
      phase   <= PH_CTRL;
      sel     <= 1'b0;
      rd      <= 1'b0;
      miso_q  <= 1'b0;
    end else begin
      if (rise) begin
        rx_sh   <= byte_in[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          case (phase)
            PH_CTRL: begin
              sel   <= match;
              rd    <= byte_in[0];
              phase <= PH_ADDR;
            end
            PH_ADDR: begin
              ptr   <= byte_in;
              tx_sh <= rd_load;
              phase <= PH_DATA;
            end
            default: begin
              ptr   <= ptr_adv;
              tx_sh <= rd_load;
            end
          endcase
        end
      end
      if (fall && phase == PH_DATA) begin
        miso_q <= tx_sh[7];
        tx_sh  <= {tx_sh[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_dir  <= 8'hFF;
      r_pol  <= '0;
      r_ien  <= '0;
      r_dflt <= '0;
      r_icon <= '0;
      r_cfg  <= '0;
      r_pu   <= '0;
      r_lat  <= '0;
    end else if (wr_en) begin
      case (ptr)
        8'h00:        r_dir  <= byte_in;
        8'h01:        r_pol  <= byte_in;
        8'h02:        r_ien  <= byte_in;
        8'h03:        r_dflt <= byte_in;
        8'h04:        r_icon <= byte_in;
        8'h05:        r_cfg  <= byte_in;
        8'h06:        r_pu   <= byte_in;
        8'h09, 8'h0A: r_lat  <= byte_in;
        default: ;
      endcase
    end
  end

  assign pad_out = r_lat;
  assign pad_oe  = ~r_dir;
  assign miso    = miso_q;
  assign miso_oe = sel && rd && phase == PH_DATA && !cs_s;

  a_r3_oe_after_addr_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> $past(byte_done));
  a_r11_cs_abort: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bit_cnt == 3'd0 && phase == PH_CTRL && !sel));
  a_r5_latch_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(r_lat) |-> $past(rise));
  a_r9_unselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(r_dir) && $stable(r_lat) && $stable(r_cfg)));
  a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_DATA && r_cfg[SEQ_BIT]) |=> $stable(ptr));
  a_r4_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase == PH_DATA && !r_cfg[SEQ_BIT] && ptr == LAST_REG) |=> ptr == 8'h00);
endmodule

// File: tb/tb_spi_gpio_expander.sv
module tb_spi_gpio_expander;
  localparam int HALF = 8;
  localparam logic [2:0] STRAP = 3'd5;
  localparam logic [7:0] CW = 8'h40 | (8'(STRAP) << 1);
  localparam logic [7:0] CR = CW | 8'h01;

  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0;
  logic [7:0] pad_in = 8'h00;
  logic miso, miso_oe;
  logic [7:0] pad_out, pad_oe;

  spi_gpio_expander dut (
    .clk(clk), .rst_n(rst_n), .strap_addr(STRAP), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .miso_oe(miso_oe), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit settled = 0, done = 0;
  int bitidx = 0, early_oe = 0, any_oe = 0;
  logic [7:0] tx_q[$], rx_q[$], dq[$], exp_q[$];
  logic [7:0] mreg [0:10];

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!cs_n && miso_oe) begin
      any_oe++;
      if (bitidx < 15) early_oe++;
    end
    if (settled) begin
      chk(pad_out == mreg[10], "R5 pad_out", pad_out, mreg[10]);
      chk(pad_oe == ~mreg[0], "R5 pad_oe", pad_oe, ~mreg[0]);
      chk(!miso_oe, "R3 idle oe", {7'd0, miso_oe}, 8'h00);
    end
  end

  function automatic logic [7:0] mrd(input logic [7:0] a);
    if (a == 8'h09) return pad_in ^ mreg[1];
    if (a > 8'h0A || a == 8'h07 || a == 8'h08) return 8'h00;
    return mreg[a[3:0]];
  endfunction

  task automatic mwr(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h09 || a == 8'h0A) mreg[10] = d;
    else if (a <= 8'h06) mreg[a[3:0]] = d;
  endtask

  task automatic spi_frame(input int cut_bits);
    logic [7:0] cap;
    int nbits;
    rx_q.delete();
    early_oe = 0; any_oe = 0; bitidx = 0; cap = 0;
    nbits = tx_q.size() * 8;
    cs_n = 0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < nbits && k != cut_bits; k++) begin
      bitidx = k;
      mosi = tx_q[k/8][7-(k%8)];
      repeat (HALF) @(negedge clk);
      cap = {cap[6:0], miso};
      sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
      if (k % 8 == 7) rx_q.push_back(cap);
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    bitidx = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic xact(input logic [7:0] ctrl, input logic [7:0] ra, input int n, input string req);
    logic [7:0] p;
    bit acc, rdf, seq;
    settled = 0;
    tx_q.delete();
    tx_q.push_back(ctrl);
    tx_q.push_back(ra);
    for (int i = 0; i < n; i++) tx_q.push_back(ctrl[0] ? 8'h00 : dq[i]);
    spi_frame(-1);
    acc = ctrl[7:4] == 4'b0100 && (!mreg[5][3] || ctrl[3:1] == STRAP);
    rdf = ctrl[0];
    exp_q.delete();
    p = ra;
    if (acc) begin
      for (int i = 0; i < n; i++) begin
        seq = mreg[5][5];
        if (rdf) exp_q.push_back(mrd(p));
        else mwr(p, dq[i]);
        if (!seq) p = (p >= 8'h0A) ? 8'h00 : p + 8'h01;
      end
    end
    if (acc && rdf) begin
      for (int i = 0; i < n; i++)
        chk(rx_q[i+2] == exp_q[i], req, rx_q[i+2], exp_q[i]);
      chk(early_oe == 0, "R3 oe before data", 8'(early_oe), 8'h00);
      chk(any_oe > 0, "R3 oe in data", 8'(any_oe), 8'h01);
    end else begin
      chk(any_oe == 0, {req, " oe"}, 8'(any_oe), 8'h00);
    end
    dq.delete();
    settled = 1;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    for (int i = 0; i <= 10; i++) mreg[i] = 8'h00;
    mreg[0] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(pad_oe == 8'h00, "R1 pad_oe", pad_oe, 8'h00);
    chk(pad_out == 8'h00, "R1 pad_out", pad_out, 8'h00);
    chk(!miso_oe, "R1 miso_oe", {7'd0, miso_oe}, 8'h00);
    settled = 1;
    xact(CR, 8'h00, 11, "R1 R2 reset burst");

    dq = '{8'hF0}; xact(CW, 8'h00, 1, "R5 dir");
    dq = '{8'h5A}; xact(CW, 8'h0A, 1, "R5 lat");
    chk(pad_oe == 8'h0F, "R5 oe value", pad_oe, 8'h0F);
    chk(pad_out == 8'h5A, "R5 out value", pad_out, 8'h5A);

    pad_in = 8'hC3;
    dq = '{8'h0F}; xact(CW, 8'h01, 1, "R6 pol");
    xact(CR, 8'h09, 1, "R6 port read");
    xact(CR, 8'h09, 4, "R4 wrap burst");

    dq = '{8'h3C}; xact(CW, 8'h09, 1, "R5 port write");
    xact(CR, 8'h0A, 1, "R5 latch read");

    dq = '{8'h11, 8'h22, 8'h33}; xact(CW, 8'h02, 3, "R4 burst write");
    dq = '{8'h99}; xact(CW, 8'h06, 1, "R7 pullup");
    xact(CR, 8'h02, 5, "R7 storage readback");

    dq = '{8'hAA}; xact(CW, 8'h07, 1, "R7 flags write");
    dq = '{8'hBB}; xact(CW, 8'h08, 1, "R7 capture write");
    dq = '{8'hCC}; xact(CW, 8'h0C, 1, "R7 high write");
    xact(CR, 8'h07, 2, "R7 zero regs");
    xact(CR, 8'h0C, 2, "R7 R4 high addr wrap");

    dq = '{8'h26}; xact(CW, 8'h05, 1, "R12 cfg write");
    xact(CR, 8'h05, 2, "R12 R8 cfg readback");
    xact(CR, 8'h00, 3, "R8 hold read");
    dq = '{8'h01, 8'h02, 8'h03}; xact(CW, 8'h0A, 3, "R8 hold write");
    chk(pad_out == 8'h03, "R8 last byte", pad_out, 8'h03);

    dq = '{8'h08}; xact(CW, 8'h05, 1, "R9 enable match");
    dq = '{8'h77}; xact(8'h44, 8'h0A, 1, "R9 foreign write");
    chk(pad_out == 8'h03, "R9 ignored", pad_out, 8'h03);
    xact(8'h45, 8'h0A, 1, "R9 foreign read");
    xact(CR, 8'h0A, 1, "R9 own read");
    dq = '{8'h00}; xact(CW, 8'h05, 1, "R9 disable match");
    dq = '{8'h66}; xact(8'h42, 8'h0A, 1, "R9 any address");
    chk(pad_out == 8'h66, "R9 accepted", pad_out, 8'h66);

    dq = '{8'h55}; xact(8'h8A, 8'h0A, 1, "R10 bad family write");
    chk(pad_out == 8'h66, "R10 ignored", pad_out, 8'h66);
    xact(8'h8B, 8'h0A, 1, "R10 bad family read");

    settled = 0;
    tx_q = '{CW, 8'h0A, 8'hFF};
    spi_frame(20);
    settled = 1;
    chk(pad_out == 8'h66, "R11 abort no write", pad_out, 8'h66);
    dq = '{8'h81}; xact(CW, 8'h0A, 1, "R11 after abort");
    chk(pad_out == 8'h81, "R11 fresh frame", pad_out, 8'h81);

    pad_in = 8'h5E;
    repeat (4) @(negedge clk);
    dq = '{8'hF0}; xact(CW, 8'h01, 1, "R6 pol2");
    xact(CR, 8'h09, 1, "R6 port read2");

    done = 1;
    summary();
  end
endmodule